// File: doc/BRIEF.md
# Thresholded Event Counter Bank

This block holds a bank of four 40-bit event counters. Each counter has its own 32-bit control word. Every clock cycle the block receives, for each of 256 event sources, five 8-bit occurrence counts called lanes. Lanes 0 to 3 carry the cache-state qualifiers (modified, exclusive, shared, invalid). Lane 4 carries the all-agents qualifier for bus events.

Each counter selects one event and adds up the lanes that its unit mask enables. It then compares that per-cycle total with an 8-bit threshold. The compare can be inverted, or turned into counting of rising edges. The counter is also filtered by a privilege level that arrives with the events. One enable bit in counter 0's word switches the whole bank on or off. A combinational read port returns the value of the counter picked by a 2-bit index.

Control word layout (bit positions are part of the behaviour):
- bits 7:0: event select
- bits 15:8: unit mask
- bit 16: user enable
- bit 17: supervisor enable
- bit 18: edge mode
- bit 22: bank enable
- bit 23: invert
- bits 31:24: threshold

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset, every counter and every control word reads as zero.
- R2: When `cfg_we` is high at a clock edge, `cfg_data` is stored into the control word of slot `cfg_idx`. The new word governs counting from the next cycle onward. In the write cycle itself the old word still applies.
- R3: The qualified count is formed from the event picked by bits 7:0. It adds lane k (k = 0..3) when unit-mask bit k (control bit 8+k) is set, and lane 4 when unit-mask bit 5 (control bit 13) is set. The total saturates at 255. The lane byte for event e and lane l sits at bits [(e*5+l)*8 +: 8] of `evt_counts`.
- R4: With threshold bits 31:24 equal to zero, the condition is "qualified count is non-zero" and a counting cycle adds the full qualified count. The invert bit has no effect in this case.
- R5: With a non-zero threshold and bit 23 clear, a counting cycle adds one when the qualified count is at least the threshold.
- R6: With a non-zero threshold and bit 23 set, a counting cycle adds one when the qualified count is at most the threshold. A qualified count of zero therefore counts.
- R7: The active state is the privilege filter combined with the condition. It is tracked every cycle, whether or not the bank is enabled. With bit 18 set, the counter adds one only in a cycle where this active state is high and was low in the previous cycle.
- R8: A counter changes only while bit 22 of slot 0's control word is set. This holds for all four counters.
- R9: Bit 16 allows counting when `priv_mode` is 0 (user). Bit 17 allows counting when `priv_mode` is 1 (supervisor). If the bit for the current level is clear, the counter does not count.
- R10: `rd_value` equals the counter chosen by `rd_idx` in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_idx | input | 2 | Slot written by `cfg_data` |
| cfg_data | input | 32 | Control word value |
| priv_mode | input | 1 | Privilege of the current cycle: 0 user, 1 supervisor |
| evt_counts | input | 10240 | Per-event, per-lane 8-bit occurrence counts |
| rd_idx | input | 2 | Counter selected for reading |
| rd_value | output | 40 | Value of the selected counter |

## Verification
The events, privilege and any control write presented before rising edge N take effect in the counters at edge N. The result is visible on `rd_value` right after that edge. A control write reaches the counting decision only from edge N+1, because it first lands in a register. The bench drives inputs at the falling edge and advances its reference model at the rising edge, using the inputs it drove and the control words it holds from before that edge. It applies the pending write only after that. At the following falling edge it steps `rd_idx` through all four slots and compares each value against the model. Reading takes no cycle, so that comparison happens in the same low phase.

// File: rtl/ecb_pkg.sv
`timescale 1ns/1ps
package ecb_pkg;
  localparam int EVT_W    = 8;
  localparam int LANES    = 5;
  localparam int CTRL_W   = 32;
  localparam int UM_AGENT = 5;

  typedef logic [EVT_W-1:0] evt_t;

  typedef struct packed {
    logic [7:0] cmask;
    logic       inv;
    logic       bank_en;
    logic [2:0] rsvd;
    logic       edge_md;
    logic       sup_en;
    logic       usr_en;
    logic [7:0] umask;
    logic [7:0] sel;
  } ctrl_t;

  function automatic logic [LANES-1:0] lane_enables(input logic [7:0] um);
    return {um[UM_AGENT], um[3:0]};
  endfunction

  function automatic logic thresh_hit(input evt_t q, input logic [7:0] cm, input logic inv);
    if (cm == 8'd0) return (q != '0);
    if (inv)        return (q <= cm);
    return (q >= cm);
  endfunction

  function automatic logic priv_allows(input ctrl_t c, input logic priv);
    return priv ? c.sup_en : c.usr_en;
  endfunction
endpackage

// File: rtl/ecb_lane_sum.sv
`timescale 1ns/1ps
module ecb_lane_sum
  import ecb_pkg::*;
#(
  parameter int NUM_EVENTS = 256
) (
  input  logic [NUM_EVENTS*LANES*EVT_W-1:0] evt_counts,
  input  logic [7:0]                        sel,
  input  logic [7:0]                        umask,
  output evt_t                              qual
);
  localparam int SUM_W = EVT_W + $clog2(LANES) + 1;
  localparam logic [SUM_W-1:0] SAT = SUM_W'((1 << EVT_W) - 1);

  logic [LANES-1:0] en;
  logic [SUM_W-1:0] acc;
  logic             unused_um;

  assign en        = lane_enables(umask);
  assign unused_um = ^{umask[7:6], umask[4]};

  always_comb begin
    acc = '0;
    if (int'(sel) < NUM_EVENTS) begin
      for (int l = 0; l < LANES; l++) begin
        if (en[l])
          acc = acc + SUM_W'(evt_counts[(int'(sel)*LANES + l)*EVT_W +: EVT_W]);
      end
    end
  end

  assign qual = (acc > SAT) ? SAT[EVT_W-1:0] : acc[EVT_W-1:0];
endmodule

// File: rtl/ecb_slot.sv
`timescale 1ns/1ps
module ecb_slot
  import ecb_pkg::*;
#(
  parameter int NUM_EVENTS = 256,
  parameter int CNT_W      = 40
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [CTRL_W-1:0]                 wr_data,
  input  logic                              priv_mode,
  input  logic                              gbl_en,
  input  logic [NUM_EVENTS*LANES*EVT_W-1:0] evt_counts,
  output ctrl_t                             ctrl_q,
  output logic [CNT_W-1:0]                  cnt_q
);
  evt_t             qual;
  logic             hit;
  logic             priv_ok;
  logic             active;
  logic             prev_q;
  logic             rise;
  logic [CNT_W-1:0] step;
  logic             unused_rsvd;

  assign unused_rsvd = ^ctrl_q.rsvd;

  ecb_lane_sum #(.NUM_EVENTS(NUM_EVENTS)) u_sum (
    .evt_counts(evt_counts),
    .sel       (ctrl_q.sel),
    .umask     (ctrl_q.umask),
    .qual      (qual)
  );

  assign hit     = thresh_hit(qual, ctrl_q.cmask, ctrl_q.inv);
  assign priv_ok = priv_allows(ctrl_q, priv_mode);
  assign active  = priv_ok & hit;
  assign rise    = active & ~prev_q;

  always_comb begin
    step = '0;
    if (gbl_en) begin
      if (ctrl_q.edge_md)            step = CNT_W'(rise);
      else if (ctrl_q.cmask == 8'd0) step = active ? CNT_W'(qual) : '0;
      else                           step = CNT_W'(active);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      if (wr_en) ctrl_q <= ctrl_t'(wr_data);
      cnt_q  <= cnt_q + step;
      prev_q <= active;
    end
  end

  // R8
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gbl_en |=> $stable(cnt_q));

  // R9
  priv_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !priv_ok |=> $stable(cnt_q));

  // R7
  edge_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gbl_en && ctrl_q.edge_md) |=> ((cnt_q - $past(cnt_q)) <= CNT_W'(1)));

  // R7
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.edge_md && prev_q) |=> $stable(cnt_q));

  // R5
  thresh_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gbl_en && ctrl_q.cmask != 8'd0) |=> ((cnt_q - $past(cnt_q)) <= CNT_W'(1)));
endmodule

// File: rtl/evt_ctr_bank.sv
`timescale 1ns/1ps
module evt_ctr_bank
  import ecb_pkg::*;
#(
  parameter int NUM_EVENTS = 256,
  parameter int NUM_CTRS   = 4,
  parameter int CNT_W      = 40,
  localparam int IDX_W     = $clog2(NUM_CTRS),
  localparam int EVT_BITS  = NUM_EVENTS * LANES * EVT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [CTRL_W-1:0]   cfg_data,
  input  logic                priv_mode,
  input  logic [EVT_BITS-1:0] evt_counts,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [CNT_W-1:0]    rd_value
);
  ctrl_t            ctrl_arr [NUM_CTRS];
  logic [CNT_W-1:0] cnt_arr  [NUM_CTRS];
  logic             gbl_en;

  assign gbl_en = ctrl_arr[0].bank_en;

  for (genvar i = 0; i < NUM_CTRS; i++) begin : g_slot
    logic wr_hit;
    assign wr_hit = cfg_we && (cfg_idx == IDX_W'(i));
    ecb_slot #(.NUM_EVENTS(NUM_EVENTS), .CNT_W(CNT_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_hit),
      .wr_data   (cfg_data),
      .priv_mode (priv_mode),
      .gbl_en    (gbl_en),
      .evt_counts(evt_counts),
      .ctrl_q    (ctrl_arr[i]),
      .cnt_q     (cnt_arr[i])
    );
  end

  logic unused_ctrl;
  always_comb begin
    unused_ctrl = 1'b0;
    for (int i = 0; i < NUM_CTRS; i++) unused_ctrl = unused_ctrl ^ (^ctrl_arr[i]);
  end

  assign rd_value = cnt_arr[rd_idx];

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |=> (cnt_arr[0] == '0 && !gbl_en));
endmodule

// File: tb/sim_evt_ctr_bank.sv
`timescale 1ns/1ps
module sim_evt_ctr_bank;
  localparam int NE = 256;
  localparam int NL = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_idx = '0;
  logic [31:0]   cfg_data = '0;
  logic          priv_mode = 1'b0;
  logic [NE*NL*8-1:0] evt_counts = '0;
  logic [1:0]    rd_idx = '0;
  logic [39:0]   rd_value;

  evt_ctr_bank u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .priv_mode(priv_mode), .evt_counts(evt_counts),
    .rd_idx(rd_idx), .rd_value(rd_value)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R1";

  logic [7:0]  ev [NE][NL];
  logic [31:0] m_ctrl [4];
  logic [39:0] m_cnt  [4];
  bit          m_prev [4];

  function automatic int qual_of(input logic [31:0] w);
    int s = 0;
    int e = w[7:0];
    if (w[8])  s += ev[e][0];
    if (w[9])  s += ev[e][1];
    if (w[10]) s += ev[e][2];
    if (w[11]) s += ev[e][3];
    if (w[13]) s += ev[e][4];
    return (s > 255) ? 255 : s;
  endfunction

  function automatic bit cond_of(input logic [31:0] w, input int q);
    int cm = w[31:24];
    if (cm == 0) return q > 0;
    return w[23] ? (q <= cm) : (q >= cm);
  endfunction

  task automatic drive_events();
    for (int e = 0; e < NE; e++)
      for (int l = 0; l < NL; l++)
        evt_counts[(e*NL+l)*8 +: 8] = ev[e][l];
  endtask

  task automatic clear_events();
    for (int e = 0; e < NE; e++)
      for (int l = 0; l < NL; l++) ev[e][l] = 8'd0;
    drive_events();
  endtask

  task automatic model_step();
    bit on = m_ctrl[0][22];
    for (int i = 0; i < 4; i++) begin
      int  q   = qual_of(m_ctrl[i]);
      bit  pok = priv_mode ? m_ctrl[i][17] : m_ctrl[i][16];
      bit  act = pok && cond_of(m_ctrl[i], q);
      if (on) begin
        if (m_ctrl[i][18])            m_cnt[i] += (act && !m_prev[i]) ? 40'd1 : 40'd0;
        else if (m_ctrl[i][31:24] == 0) m_cnt[i] += act ? 40'(q) : 40'd0;
        else                           m_cnt[i] += act ? 40'd1 : 40'd0;
      end
      m_prev[i] = act;
    end
    if (cfg_we) m_ctrl[cfg_idx] = cfg_data;
  endtask

  task automatic check_all();
    for (int i = 0; i < 4; i++) begin
      rd_idx = 2'(i);
      #0.2;
      checks++;
      if (rd_value !== m_cnt[i]) begin
        errors++;
        $display("FAIL %s (R10 read) ctr%0d got %0h expected %0h", tag, i, rd_value, m_cnt[i]);
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    cfg_we = 1'b0;
    check_all();
  endtask

  task automatic wr(input int idx, input logic [31:0] w);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_data = w;
    tick();
  endtask

  function automatic logic [31:0] mk(input int cm, input logic [7:0] fl, input int um, input int sel);
    return {8'(cm), fl, 8'(um), 8'(sel)};
  endfunction

  localparam logic [7:0] USR = 8'h01, SUP = 8'h02, EDG = 8'h04, EN = 8'h40, INV = 8'h80;

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) begin m_ctrl[i] = '0; m_cnt[i] = '0; m_prev[i] = 0; end
    clear_events();
    repeat (3) @(negedge clk);
    tag = "R1";
    check_all();
    rst_n = 1'b1;
    @(negedge clk);
    check_all();

    // R2: write takes effect one cycle later; events present during the write
    tag = "R2";
    ev[3][0] = 8'd7; drive_events();
    wr(1, mk(0, USR, 8'h01, 3));
    wr(0, mk(0, EN, 8'h00, 0));
    tick(); tick();

    // R3: saturation across all lanes including the agent lane
    tag = "R3";
    wr(1, mk(0, USR, 8'h2F, 5));
    for (int l = 0; l < NL; l++) ev[5][l] = 8'd100;
    drive_events();
    tick(); tick();
    ev[5][4] = 8'd0; ev[5][1] = 8'd0; ev[5][2] = 8'd20; ev[5][3] = 8'd0; ev[5][0] = 8'd1;
    drive_events(); tick();

    // R4: zero threshold with invert set adds full count
    tag = "R4";
    wr(1, mk(0, INV | USR, 8'h01, 5));
    ev[5][0] = 8'd9; drive_events(); tick();
    ev[5][0] = 8'd0; drive_events(); tick();

    // R5: threshold compare
    tag = "R5";
    wr(2, mk(3, USR, 8'h01, 9));
    for (int k = 0; k < 6; k++) begin ev[9][0] = 8'(k); drive_events(); tick(); end

    // R6: inverted threshold, zero counts
    tag = "R6";
    wr(2, mk(2, INV | USR, 8'h01, 9));
    for (int k = 0; k < 5; k++) begin ev[9][0] = 8'(k); drive_events(); tick(); end

    // R7: edge mode
    tag = "R7";
    wr(2, mk(2, EDG | USR, 8'h01, 9));
    begin
      int pat [8] = '{0, 3, 3, 0, 5, 1, 4, 4};
      for (int k = 0; k < 8; k++) begin ev[9][0] = 8'(pat[k]); drive_events(); tick(); end
    end

    // R8: bank enable cleared freezes all counters
    tag = "R8";
    wr(0, mk(0, 8'h00, 8'h00, 0));
    ev[9][0] = 8'd0; ev[5][0] = 8'd4; drive_events();
    tick(); ev[9][0] = 8'd6; drive_events(); tick(); tick();
    wr(0, mk(0, EN, 8'h00, 0));
    tick();

    // R9: privilege filtering
    tag = "R9";
    wr(3, mk(0, SUP, 8'h01, 5));
    priv_mode = 1'b0; tick();
    priv_mode = 1'b1; tick();
    wr(3, mk(0, 8'h00, 8'h01, 5));
    tick(); priv_mode = 1'b0; tick();

    // R10: constrained random over all modes
    tag = "R10";
    for (int c = 0; c < 1500; c++) begin
      for (int e = 0; e < NE; e++)
        for (int l = 0; l < NL; l++)
          ev[e][l] = ($urandom % 16 == 0) ? 8'($urandom) : 8'($urandom % 4);
      drive_events();
      priv_mode = 1'($urandom);
      if ($urandom % 8 == 0) begin
        int idx = $urandom % 4;
        logic [7:0] fl = 8'($urandom) & 8'hC7;
        int cm = ($urandom % 3 == 0) ? 0 : ($urandom % 8);
        if (idx == 0 && ($urandom % 4 != 0)) fl = fl | EN;
        cfg_we = 1'b1; cfg_idx = 2'(idx);
        cfg_data = mk(cm, fl, $urandom, $urandom % 8);
      end
      tick();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule